// File: doc/BRIEF.md
# Ternary Red-Majority Flee Detector

This block watches a 3x3 grid of lights in which every cell carries a balanced-ternary value of -1, 0 or +1. A cell at -1 means red, and red signals danger. On each valid strobe the block counts the red cells and adds up all nine trits. One cycle later it registers a flee decision. A mode input picks the firing rule. In count mode the block fires when the number of red cells reaches a stored threshold. In sum mode it fires when the signed total falls below a fixed negative limit.

The count-mode threshold is held in a register. A host can load it directly. It also adapts on its own: in the cycle after any fire, a reward input moves the threshold up or down by one, always within a clamped range. A cell code that is not a legal trit blocks firing and raises an error flag for that sample.

Top module: `tern_flee_detect`

## Requirements
- R1: After reset, flee_o=0, err_o=0, red_cnt_o=0, sum_o=0 and thr_o=7.
- R2: Cell k occupies bits [2k+1:2k] of cells_i. The codes are 2'b10 = -1, 2'b00 = 0 and 2'b01 = +1. One clock edge after valid_i, red_cnt_o holds the number of cells coded -1.
- R3: One clock edge after valid_i, sum_o holds the signed sum of the nine trits as a 5-bit two's-complement value, in the range -9 to +9.
- R4: With mode_i=0, flee_o is 1 one edge after valid_i exactly when red_cnt >= thr_o.
- R5: With mode_i=1, flee_o is 1 one edge after valid_i exactly when the trit sum is less than -5.
- R6: If any cell carries code 2'b11, the result for that sample has flee_o=0 and err_o=1. That cell counts as 0 in both red_cnt_o and sum_o.
- R7: After an edge at which valid_i=0, flee_o=0 and err_o=0, and red_cnt_o and sum_o keep their previous values.
- R8: thr_load_i=1 loads thr_val_i clamped to 1..9 into thr_o at the next edge. A load takes priority over adaptation.
- R9: While flee_o=1, reward_i=2'b10 raises thr_o by one (saturating at 9) and reward_i=2'b01 lowers it by one (saturating at 1). Codes 2'b00 and 2'b11, or any reward while flee_o=0, leave thr_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cells_i | input | 18 | Nine 2-bit trit codes, cell k at [2k+1:2k] |
| valid_i | input | 1 | Sample strobe for cells_i |
| mode_i | input | 1 | 0 = red-count rule, 1 = signed-sum rule |
| thr_load_i | input | 1 | Load the threshold |
| thr_val_i | input | 4 | Threshold value to load (clamped) |
| reward_i | input | 2 | Reward trit applied in the cycle after a fire |
| flee_o | output | 1 | Registered flee decision |
| err_o | output | 1 | Registered illegal-code flag |
| red_cnt_o | output | 4 | Registered number of red cells |
| sum_o | output | 5 | Registered signed trit sum |
| thr_o | output | 4 | Current count-mode threshold |

## Verification
The assertions assume that the control inputs (valid_i, mode_i, thr_load_i and reward_i) carry known values at every clock edge after reset. They make no assumption about the cell codes, so illegal 2'b11 codes are allowed. The bench changes every input only on the falling edge, and it keeps reward_i at 2'b00 during the pattern sweeps so that the threshold moves only in the tests that target it. The sweeps cover all 19,683 legal grids in both modes. A separate set of graded red patterns covers every threshold value.

// File: rtl/tfd_pkg.sv
package tfd_pkg;
   localparam logic [1:0] TRIT_ZERO = 2'b00;
   localparam logic [1:0] TRIT_POS  = 2'b01;
   localparam logic [1:0] TRIT_NEG  = 2'b10;
   localparam logic [1:0] TRIT_BAD  = 2'b11;

   typedef enum logic {
      RULE_COUNT = 1'b0,
      RULE_SUM   = 1'b1
   } rule_e;
endpackage

// File: rtl/tfd_trit_cell.sv
module tfd_trit_cell
   import tfd_pkg::*;
(
   input  logic [1:0] code_i,
   output logic       neg_o,
   output logic       pos_o,
   output logic       bad_o
);
   always_comb begin
      neg_o = (code_i == TRIT_NEG);
      pos_o = (code_i == TRIT_POS);
      bad_o = (code_i == TRIT_BAD);
   end
endmodule

// File: rtl/tfd_reduce.sv
module tfd_reduce #(
   parameter int N_CELLS = 9,
   parameter int CNT_W   = $clog2(N_CELLS + 1),
   parameter int SUM_W   = CNT_W + 1
) (
   input  logic [N_CELLS-1:0] neg_i,
   input  logic [N_CELLS-1:0] pos_i,
   output logic [CNT_W-1:0]   cnt_o,
   output logic [SUM_W-1:0]   sum_o
);
   always_comb begin
      cnt_o = '0;
      sum_o = '0;
      for (int i = 0; i < N_CELLS; i++) begin
         cnt_o = cnt_o + CNT_W'(neg_i[i]);
         sum_o = sum_o + SUM_W'(pos_i[i]) - SUM_W'(neg_i[i]);
      end
   end
endmodule

// File: rtl/tfd_thresh.sv
module tfd_thresh
   import tfd_pkg::*;
#(
   parameter int THR_W     = 4,
   parameter int THR_MIN   = 1,
   parameter int THR_MAX   = 9,
   parameter int THR_RESET = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [THR_W-1:0] load_val_i,
   input  logic             adapt_i,
   input  logic [1:0]       reward_i,
   output logic [THR_W-1:0] thr_o
);
   localparam logic [THR_W-1:0] MIN_V = THR_W'(THR_MIN);
   localparam logic [THR_W-1:0] MAX_V = THR_W'(THR_MAX);
   localparam logic [THR_W-1:0] RST_V = THR_W'(THR_RESET);

   logic [THR_W-1:0] thr_q, thr_d;

   always_comb begin
      thr_d = thr_q;
      if (load_i) begin
         if (load_val_i < MIN_V)      thr_d = MIN_V;
         else if (load_val_i > MAX_V) thr_d = MAX_V;
         else                         thr_d = load_val_i;
      end else if (adapt_i && reward_i == TRIT_NEG && thr_q < MAX_V) begin
         thr_d = thr_q + 1'b1;
      end else if (adapt_i && reward_i == TRIT_POS && thr_q > MIN_V) begin
         thr_d = thr_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) thr_q <= RST_V;
      else        thr_q <= thr_d;
   end

   assign thr_o = thr_q;

   assert_thr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_q >= MIN_V) && (thr_q <= MAX_V));

   assert_thr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !(adapt_i && (reward_i == TRIT_NEG || reward_i == TRIT_POS)))
      |=> $stable(thr_q));

   assert_thr_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && adapt_i && reward_i == TRIT_NEG && thr_q < MAX_V)
      |=> (thr_q == $past(thr_q) + 1'b1));
endmodule

// File: rtl/tern_flee_detect.sv
module tern_flee_detect
   import tfd_pkg::*;
#(
   parameter int N_CELLS   = 9,
   parameter int THR_RESET = 7,
   parameter int THR_MIN   = 1,
   parameter int SUM_LIMIT = -5,
   parameter int CNT_W     = $clog2(N_CELLS + 1),
   parameter int SUM_W     = CNT_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2*N_CELLS-1:0] cells_i,
   input  logic                 valid_i,
   input  logic                 mode_i,
   input  logic                 thr_load_i,
   input  logic [CNT_W-1:0]     thr_val_i,
   input  logic [1:0]           reward_i,
   output logic                 flee_o,
   output logic                 err_o,
   output logic [CNT_W-1:0]     red_cnt_o,
   output logic [SUM_W-1:0]     sum_o,
   output logic [CNT_W-1:0]     thr_o
);
   localparam logic signed [SUM_W-1:0] SUM_LIM_V = SUM_W'(SUM_LIMIT);
   localparam logic [CNT_W-1:0]        N_V       = CNT_W'(N_CELLS);

   if (N_CELLS < 1 || N_CELLS > 64) begin : g_bad_cells
      $error("tern_flee_detect: N_CELLS out of range");
   end
   if (THR_MIN < 1 || THR_RESET < THR_MIN || THR_RESET > N_CELLS) begin : g_bad_thr
      $error("tern_flee_detect: threshold reset value out of range");
   end
   if (SUM_LIMIT >= 0 || -SUM_LIMIT > N_CELLS) begin : g_bad_lim
      $error("tern_flee_detect: SUM_LIMIT must be negative and reachable");
   end

   logic [N_CELLS-1:0] neg_w, pos_w, bad_w;

   for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
      tfd_trit_cell u_cell (
         .code_i (cells_i[2*k +: 2]),
         .neg_o  (neg_w[k]),
         .pos_o  (pos_w[k]),
         .bad_o  (bad_w[k])
      );
   end

   logic [CNT_W-1:0] cnt_c;
   logic [SUM_W-1:0] sum_c;

   tfd_reduce #(.N_CELLS(N_CELLS), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_reduce (
      .neg_i (neg_w),
      .pos_i (pos_w),
      .cnt_o (cnt_c),
      .sum_o (sum_c)
   );

   logic [CNT_W-1:0] thr_w;
   logic             flee_q;

   tfd_thresh #(
      .THR_W     (CNT_W),
      .THR_MIN   (THR_MIN),
      .THR_MAX   (N_CELLS),
      .THR_RESET (THR_RESET)
   ) u_thresh (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (thr_load_i),
      .load_val_i (thr_val_i),
      .adapt_i    (flee_q),
      .reward_i   (reward_i),
      .thr_o      (thr_w)
   );

   logic any_bad, cnt_fire, sum_fire, fire_c;
   always_comb begin
      any_bad  = |bad_w;
      cnt_fire = (cnt_c >= thr_w);
      sum_fire = ($signed(sum_c) < SUM_LIM_V);
      fire_c   = (rule_e'(mode_i) == RULE_SUM) ? sum_fire : cnt_fire;
   end

   logic             err_q;
   logic [CNT_W-1:0] cnt_q;
   logic [SUM_W-1:0] sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flee_q <= 1'b0;
         err_q  <= 1'b0;
         cnt_q  <= '0;
         sum_q  <= '0;
      end else begin
         flee_q <= valid_i & fire_c & ~any_bad;
         err_q  <= valid_i & any_bad;
         if (valid_i) begin
            cnt_q <= cnt_c;
            sum_q <= sum_c;
         end
      end
   end

   assign flee_o    = flee_q;
   assign err_o     = err_q;
   assign red_cnt_o = cnt_q;
   assign sum_o     = sum_q;
   assign thr_o     = thr_w;

   assert_err_blocks_flee_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !flee_o);

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> (!flee_o && !err_o && $stable(red_cnt_o) && $stable(sum_o)));

   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      red_cnt_o <= N_V);

   assert_sum_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(sum_o) >= -$signed({1'b0, N_V})) && ($signed(sum_o) <= $signed({1'b0, N_V})));

   assert_sum_vs_cnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $signed(sum_o) <= $signed(SUM_W'(N_CELLS) - SUM_W'(red_cnt_o) - SUM_W'(red_cnt_o)));
endmodule

// File: tb/tern_flee_detect_tb.sv
`timescale 1ns/1ps
module tern_flee_detect_tb;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [17:0] cells = '0;
   logic        valid = 0;
   logic        mode = 0;
   logic        tload = 0;
   logic [3:0]  tval = '0;
   logic [1:0]  reward = 2'b00;
   logic        flee, err;
   logic [3:0]  cnt, thr;
   logic [4:0]  sum;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   tern_flee_detect u_dut (
      .clk(clk), .rst_n(rst_n), .cells_i(cells), .valid_i(valid), .mode_i(mode),
      .thr_load_i(tload), .thr_val_i(tval), .reward_i(reward),
      .flee_o(flee), .err_o(err), .red_cnt_o(cnt), .sum_o(sum), .thr_o(thr)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic apply(input logic [17:0] c, input logic v);
      @(negedge clk);
      cells = c; valid = v;
      @(posedge clk);
      #1;
      valid = 0;
   endtask

   task automatic load_thr(input logic [3:0] v);
      @(negedge clk);
      tload = 1; tval = v;
      @(posedge clk);
      #1;
      tload = 0;
   endtask

   // grid with the first r cells red and the rest +1
   function automatic logic [17:0] graded(input int r);
      logic [17:0] c;
      for (int k = 0; k < 9; k++) c[2*k +: 2] = (k < r) ? 2'b10 : 2'b01;
      return c;
   endfunction

   // fire with all-red grid, then apply reward (and optional load) one cycle later
   task automatic fire_reward(input logic [1:0] r, input logic ld, input logic [3:0] lv);
      apply(18'h2AAAA, 1'b1);
      @(negedge clk);
      reward = r; tload = ld; tval = lv;
      @(posedge clk);
      #1;
      reward = 2'b00; tload = 0;
   endtask

   initial begin
      #4000000;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 flee", flee, 0);
      chk("R1 err", err, 0);
      chk("R1 cnt", cnt, 0);
      chk("R1 sum", $signed(sum), 0);
      chk("R1 thr", thr, 7);
      @(negedge clk);
      rst_n = 1;

      // R2 R3 R4 R5: exhaustive sweep of legal grids in both modes
      for (int m = 0; m < 2; m++) begin
         mode = m[0];
         for (int p = 0; p < 19683; p++) begin
            logic [17:0] c;
            int q, nr, s, ef;
            q = p; nr = 0; s = 0;
            for (int k = 0; k < 9; k++) begin
               case (q % 3)
                  0: c[2*k +: 2] = 2'b00;
                  1: begin c[2*k +: 2] = 2'b01; s++; end
                  default: begin c[2*k +: 2] = 2'b10; s--; nr++; end
               endcase
               q = q / 3;
            end
            apply(c, 1'b1);
            ef = (m == 0) ? int'(nr >= 7) : int'(s < -5);
            chk("R2 red count", cnt, nr);
            chk("R3 sum", $signed(sum), s);
            chk(m == 0 ? "R4 count-rule flee" : "R5 sum-rule flee", flee, ef);
            chk("R6 err clear on legal codes", err, 0);
         end
      end

      // R6 illegal code in cell 4, other cells red
      for (int m = 0; m < 2; m++) begin
         mode = m[0];
         apply(18'h2AAAA ^ (18'h1 << 8) | (18'h3 << 8), 1'b1);
         chk("R6 flee suppressed", flee, 0);
         chk("R6 err raised", err, 1);
         chk("R6 cnt", cnt, 8);
         chk("R6 sum", $signed(sum), -8);
      end

      // R7 no valid: outputs quiet, counts held
      mode = 0;
      apply(graded(3), 1'b1);
      apply(18'h2AAAA, 1'b0);
      chk("R7 flee idle", flee, 0);
      chk("R7 err idle", err, 0);
      chk("R7 cnt held", cnt, 3);
      chk("R7 sum held", $signed(sum), 3);

      // R8 load with clamping
      load_thr(4'd0);  chk("R8 load 0 clamps", thr, 1);
      load_thr(4'd15); chk("R8 load 15 clamps", thr, 9);
      load_thr(4'd5);  chk("R8 load 5", thr, 5);

      // R4 every threshold against graded red counts
      mode = 0;
      for (int t = 1; t <= 9; t++) begin
         load_thr(t[3:0]);
         for (int r = 0; r <= 9; r++) begin
            apply(graded(r), 1'b1);
            chk("R4 threshold sweep", flee, int'(r >= t));
         end
      end

      // R9 adaptation
      load_thr(4'd7);
      fire_reward(2'b10, 0, 0); chk("R9 negative reward raises", thr, 8);
      fire_reward(2'b01, 0, 0); chk("R9 positive reward lowers", thr, 7);
      fire_reward(2'b00, 0, 0); chk("R9 zero reward holds", thr, 7);
      fire_reward(2'b11, 0, 0); chk("R9 code 11 holds", thr, 7);
      load_thr(4'd9);
      fire_reward(2'b10, 0, 0); chk("R9 saturate high", thr, 9);
      load_thr(4'd1);
      fire_reward(2'b01, 0, 0); chk("R9 saturate low", thr, 1);
      load_thr(4'd7);
      apply(graded(2), 1'b1);
      @(negedge clk); reward = 2'b10; @(posedge clk); #1; reward = 2'b00;
      chk("R9 no fire no change", thr, 7);
      fire_reward(2'b10, 1, 4'd3); chk("R8 load beats reward", thr, 3);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule